// File: doc/BRIEF.md
# Counter-Compare Level Conversion Engine

This block turns a set of per-channel gray-level codes into track/hold timing for a bank of analog hold switches. Every channel owns a code that has already been latched upstream. A single transfer strobe copies all of these codes into a second set of comparator registers at once. The same strobe then starts a conversion. During the conversion one shared counter steps up on each count pulse, and every channel compares that counter with its own code.

Each channel has a track enable. While the enable is high, that channel's hold switch is closed and its capacitor follows an external ramp. When the counter reaches the channel's code the enable drops and stays low, so the capacitor holds the ramp voltage that was present at that moment. The ramp generator and the analog output stage are outside this block. Because the staging codes and the comparator codes are separate registers, the next line of data can be presented while the current conversion runs.

Top module: `level_engine`

## Requirements
- R1: After reset all track enables are 0 and `conv_done` is 0.
- R2: On a rising edge of `load_strobe`, the comparator code of every channel becomes the value on `stage_codes`. Channel i takes its code from `stage_codes[i*CW +: CW]`.
- R3: While `load_strobe` is high, and from the rising edge onwards, every track enable is 0 and `conv_done` is 0.
- R4: On a falling edge of `load_strobe` the shared counter restarts at 0. In the following cycle, the track enable of every channel with a nonzero code is 1.
- R5: Each cycle in which `count_pulse` is high during a conversion adds one to the counter. Channel i's track enable is 1 after k pulses exactly when k is less than its code, so it drops after exactly code pulses and does not return.
- R6: A channel whose code is 0 never raises its track enable.
- R7: The counter stops at full scale (2**CW-1, that is 127 when CW=7). `conv_done` is 1 exactly when a conversion has reached full scale. Further pulses keep it at 1 without wrapping the counter.
- R8: Changes on `stage_codes` during a conversion have no effect on the track enables until the next rising edge of `load_strobe`.
- R9: Count pulses that arrive while `load_strobe` is high, or before any conversion has started, do not move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_strobe | input | 1 | Transfer strobe. The rising edge loads the codes and the falling edge starts the conversion |
| count_pulse | input | 1 | Count advance, one step per high cycle |
| stage_codes | input | NCH*CW | Staged codes, CW bits per channel, channel 0 in the low bits |
| track_en | output | NCH | Per-channel track enable. 1 means the hold switch is closed |
| conv_done | output | 1 | Counter at full scale during a conversion |

## Verification
The bench builds the block with its default parameters: 32 channels and 7-bit codes. This puts the full 0 to 127 code range within reach, so a conversion of 127 pulses covers both the zero-code channel and the saturating full-scale channel in one run. Directed codes are placed at the edges (0, 1, 126 and 127) and random codes fill the rest. The bench also reloads during a running conversion, changes the staging data while a conversion runs, and sends pulses while the strobe is high. The expected value of every enable is checked after each pulse.

// File: rtl/level_engine.sv
module level_engine #(
  parameter int NCH = 32,
  parameter int CW  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_strobe,
  input  logic              count_pulse,
  input  logic [NCH*CW-1:0] stage_codes,
  output logic [NCH-1:0]    track_en,
  output logic              conv_done
);
  localparam logic [CW-1:0] FULL = '1;

  logic              ld_q;
  logic              active;
  logic [CW-1:0]     cnt;
  logic [NCH*CW-1:0] cmp_codes;

  wire ld_rise = load_strobe & ~ld_q;
  wire ld_fall = ~load_strobe & ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_q      <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
      cmp_codes <= '0;
    end else begin
      ld_q <= load_strobe;
      if (ld_rise) begin
        cmp_codes <= stage_codes;
        active    <= 1'b0;
        cnt       <= '0;
      end else if (ld_fall) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && count_pulse && cnt != FULL) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign track_en[g] = active && (cnt < cmp_codes[g*CW +: CW]);
  end

  assign conv_done = active && (cnt == FULL);
endmodule

// File: rtl/level_engine_chk.sv
module level_engine_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load_strobe,
  input logic [NCH-1:0] track_en,
  input logic           conv_done
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (track_en == '0 && !conv_done)); // R1

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> (track_en == '0 && !conv_done)); // R3

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_strobe && !$past(load_strobe) && !$past(load_strobe, 2))
      |-> ((track_en & ~$past(track_en)) == '0)); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !load_strobe) |=> conv_done); // R7

  AST_DONE_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (track_en == '0)); // R7
endmodule

bind level_engine level_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_strobe(load_strobe),
  .track_en(track_en), .conv_done(conv_done)
);

// File: tb/test_level_engine.sv
module test_level_engine;
  localparam int NCH   = 32;
  localparam int CW    = 7;
  localparam int FS    = (1 << CW) - 1;
  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_strobe = 1'b0;
  logic              count_pulse = 1'b0;
  logic [NCH*CW-1:0] stage_codes = '0;
  logic [NCH-1:0]    track_en;
  logic              conv_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [CW-1:0] ref_codes [NCH];
  logic [CW-1:0] alt_codes [NCH];

  level_engine #(.NCH(NCH), .CW(CW)) i_level_engine (
    .clk(clk), .rst_n(rst_n), .load_strobe(load_strobe),
    .count_pulse(count_pulse), .stage_codes(stage_codes),
    .track_en(track_en), .conv_done(conv_done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] pack(input logic [CW-1:0] c [NCH]);
    logic [NCH*CW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = c[i];
    return v;
  endfunction

  function automatic logic [NCH-1:0] exp_track(input logic [CW-1:0] c [NCH], input int k);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (k < int'(c[i]));
    return v;
  endfunction

  task automatic fill_random(output logic [CW-1:0] c [NCH]);
    for (int i = 0; i < NCH; i++) c[i] = CW'($urandom);
    c[0] = '0; c[1] = 1; c[2] = CW'(FS - 1); c[3] = CW'(FS);
  endtask

  task automatic start_conv(input logic [CW-1:0] c [NCH], input int pulses_in_load);
    stage_codes = pack(c);
    load_strobe = 1'b1;
    tick();
    check(track_en == '0 && !conv_done, "R3 load high", {31'd0, conv_done, track_en}, 64'd0);
    for (int p = 0; p < pulses_in_load; p++) begin
      count_pulse = 1'b1; tick();
    end
    count_pulse = 1'b0;
    tick();
    load_strobe = 1'b0;
    tick();
  endtask

  task automatic run_pulses(input logic [CW-1:0] c [NCH], input int from, input int upto, input string req);
    for (int k = from; k <= upto; k++) begin
      check(track_en == exp_track(c, k), req, track_en, exp_track(c, k));
      check(conv_done == (k >= FS), "R7 done", conv_done, (k >= FS));
      if (k < upto) begin
        count_pulse = 1'b1; tick(); count_pulse = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    check(track_en == '0 && !conv_done, "R1 reset", {31'd0, conv_done, track_en}, 64'd0);
    rst_n = 1'b1;
    count_pulse = 1'b1; tick(); tick(); count_pulse = 1'b0;
    check(track_en == '0 && !conv_done, "R9 idle pulses", {31'd0, conv_done, track_en}, 64'd0);
  endtask

  task automatic t_full_sweep();
    fill_random(ref_codes);
    start_conv(ref_codes, 0);
    check(track_en == exp_track(ref_codes, 0), "R4 start", track_en, exp_track(ref_codes, 0));
    check(track_en[0] == 1'b0, "R6 zero code", track_en[0], 0);
    run_pulses(ref_codes, 0, FS + 3, "R5 sweep");
    check(track_en[0] == 1'b0, "R6 zero code end", track_en[0], 0);
  endtask

  task automatic t_pulses_in_load();
    fill_random(ref_codes);
    start_conv(ref_codes, 9);
    check(track_en == exp_track(ref_codes, 0), "R9 pulses during load", track_en, exp_track(ref_codes, 0));
    run_pulses(ref_codes, 0, 20, "R9 count after load");
  endtask

  task automatic t_restage();
    fill_random(ref_codes);
    fill_random(alt_codes);
    for (int i = 0; i < NCH; i++) alt_codes[i] = ~ref_codes[i];
    start_conv(ref_codes, 0);
    run_pulses(ref_codes, 0, 10, "R5 pre restage");
    stage_codes = pack(alt_codes);
    tick();
    run_pulses(ref_codes, 10, FS, "R8 restage ignored");
    load_strobe = 1'b1;
    tick();
    check(track_en == '0 && !conv_done, "R3 reload clears", {31'd0, conv_done, track_en}, 64'd0);
    tick();
    load_strobe = 1'b0;
    tick();
    run_pulses(alt_codes, 0, 40, "R2 new codes");
  endtask

  task automatic t_reload_mid();
    fill_random(ref_codes);
    start_conv(ref_codes, 0);
    run_pulses(ref_codes, 0, 30, "R5 first half");
    fill_random(alt_codes);
    start_conv(alt_codes, 0);
    check(track_en == exp_track(alt_codes, 0), "R4 restart counter", track_en, exp_track(alt_codes, 0));
    run_pulses(alt_codes, 0, FS + 1, "R2 reload mid conversion");
  endtask

  initial begin
    t_reset();
    t_full_sweep();
    t_pulses_in_load();
    t_restage();
    t_reload_mid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule